// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between an on-chip requester and an external asynchronous static RAM with 16-bit words and two byte lanes. The requester presents a request with a direction flag, a word address, write data and a per-lane byte mask. The block accepts it while idle, then drives the memory's active-low select, write strobe, output strobe and lane enables, plus a data bus with its own drive-enable. It returns a single-cycle completion pulse and, for reads, the captured word.

Every phase of a memory cycle lasts a compile-time number of system clocks: address setup before the write strobe, write strobe width, hold after the strobe, and read access time. The clock period and these counts together meet the memory's minimum timings. A read always adds one sampling clock after the access phase. When the direction changes, a configurable number of deselected clocks separate the two cycles, so the memory and the controller never drive the bus together.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_ce_n, mem_we_n and mem_oe_n are 1, every mem_be_n bit is 1, mem_dq_oe is 0, req_ready is 1 and rsp_done is 0.
- R2: A write with a nonzero mask, accepted at a rising edge (req_valid and req_ready both 1), holds mem_ce_n low for SETUP_CYC+PULSE_CYC+HOLD_CYC cycles. mem_we_n is low for exactly PULSE_CYC of those cycles, after SETUP_CYC cycles with mem_we_n high. rsp_done is 1 in the cycle after the SETUP_CYC+PULSE_CYC+HOLD_CYC-th edge following acceptance, when no turnaround applies.
- R3: While mem_ce_n stays low, mem_addr and mem_be_n do not change.
- R4: mem_dq_oe is 1 whenever mem_we_n is 0, and in the cycle after mem_we_n was 0 the bus is still driven with the chip still selected.
- R5: A read with a nonzero mask holds mem_ce_n and mem_oe_n low and mem_we_n high, with the bus released, for RD_CYC+1 cycles. rsp_done and rsp_rdata appear RD_CYC+1 edges after acceptance, when no turnaround applies.
- R6: Mask bit 0 drives mem_be_n[0] and controls data bits 7:0. Mask bit 1 drives mem_be_n[1] and controls bits 15:8. A write changes only the lanes whose mask bit is 1.
- R7: In rsp_rdata, a lane whose mask bit was 0 reads as zero. A selected lane carries the stored byte.
- R8: A request with mask 0 gives rsp_done one edge after acceptance, never lowers mem_ce_n, leaves memory contents unchanged, and does not count as the last direction for R9.
- R9: When a request's direction differs from the last completed nonzero-mask request, TURN_CYC deselected cycles are added before its memory cycle. A request in the same direction, or the first request, has no such gap.
- R10: mem_oe_n is low only while mem_we_n is high and mem_dq_oe is 0.
- R11: req_ready is 1 only while the chip is deselected, and each accepted request produces exactly one rsp_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_mask | input | DW/8 | Byte-lane mask, bit 0 = bits 7:0 |
| req_ready | output | 1 | Controller idle, request accepted this edge if valid |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read word, unselected lanes zero |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_be_n | output | DW/8 | Lane enables, active low |
| mem_dq_out | output | DW | Data driven toward memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | DW | Data from memory |

## Verification
The completion of one memory cycle and the acceptance of the next request fall in the same idle cycle. When the two directions differ, the turnaround decision must also be made in that same cycle. The bench issues requests back to back, first in one direction, then alternating, and mixes in mask-zero requests that must not disturb the remembered direction. It judges each request by the exact number of edges to rsp_done against the phase-length sum plus any turnaround. A memory model counts every cycle in which both sides could drive the bus, and every cycle in which the write strobe is low while the bus is not driven.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TURN   = 3'd1,
        ST_WSETUP = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WHOLD  = 3'd4,
        ST_RACC   = 3'd5,
        ST_RSAMP  = 3'd6
    } seq_state_e;

    localparam int LANE_W = 8;

endpackage

// File: rtl/sram_ctrl_lane.sv
module sram_ctrl_lane
    import sram_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              sel_in,
    input  logic [LANE_W-1:0] wdata_in,
    input  logic              active,
    input  logic              capture,
    input  logic [LANE_W-1:0] dq_in,
    output logic              en_n,
    output logic [LANE_W-1:0] dq_out,
    output logic [LANE_W-1:0] rdata
);

    typedef struct packed {
        logic              sel;
        logic [LANE_W-1:0] wdat;
        logic [LANE_W-1:0] rdat;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        if (load) begin
            lane_d.sel  = sel_in;
            lane_d.wdat = wdata_in;
        end
        if (capture) begin
            lane_d.rdat = lane_q.sel ? dq_in : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign en_n   = ~(lane_q.sel & active);
    assign dq_out = lane_q.wdat;
    assign rdata  = lane_q.rdat;

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int AW        = 16,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 1,
    parameter int HOLD_CYC  = 1,
    parameter int RD_CYC    = 2,
    parameter int TURN_CYC  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic          mask_zero,
    output logic          req_ready,
    output logic          accept,
    output logic          capture,
    output logic          done,
    output logic          active,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_dq_oe
);

    localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_B = (HOLD_CYC > RD_CYC) ? HOLD_CYC : RD_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAXC  = (MAX_C > TURN_CYC) ? MAX_C : TURN_CYC;
    localparam int CW    = $clog2(MAXC + 1);

    localparam logic [CW-1:0] LD_SETUP = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] LD_PULSE = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] LD_HOLD  = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] LD_RD    = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] LD_TURN  = CW'(TURN_CYC - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic          wr;
        logic          last_wr;
        logic          last_vld;
        logic          ce_n;
        logic          we_n;
        logic          oe_n;
        logic          dq_oe;
        logic          done;
    } seq_t;

    seq_t seq_d, seq_q;

    function automatic seq_t seq_idle();
        seq_t s;
        s       = '0;
        s.state = ST_IDLE;
        s.ce_n  = 1'b1;
        s.we_n  = 1'b1;
        s.oe_n  = 1'b1;
        return s;
    endfunction

    function automatic seq_t launch(seq_t s, logic wr);
        seq_t r;
        r      = s;
        r.ce_n = 1'b0;
        r.we_n = 1'b1;
        if (wr) begin
            r.state = ST_WSETUP;
            r.cnt   = LD_SETUP;
            r.oe_n  = 1'b1;
            r.dq_oe = 1'b1;
        end else begin
            r.state = ST_RACC;
            r.cnt   = LD_RD;
            r.oe_n  = 1'b0;
            r.dq_oe = 1'b0;
        end
        return r;
    endfunction

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (mask_zero) begin
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.addr = req_addr;
                        seq_d.wr   = req_write;
                        if (seq_q.last_vld && (seq_q.last_wr != req_write)) begin
                            seq_d.state = ST_TURN;
                            seq_d.cnt   = LD_TURN;
                        end else begin
                            seq_d = launch(seq_d, req_write);
                        end
                    end
                end
            end
            ST_TURN: begin
                if (seq_q.cnt == '0) begin
                    seq_d = launch(seq_d, seq_q.wr);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_WSETUP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = ST_WPULSE;
                    seq_d.cnt   = LD_PULSE;
                    seq_d.we_n  = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_WPULSE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = ST_WHOLD;
                    seq_d.cnt   = LD_HOLD;
                    seq_d.we_n  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_WHOLD: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state    = ST_IDLE;
                    seq_d.ce_n     = 1'b1;
                    seq_d.dq_oe    = 1'b0;
                    seq_d.done     = 1'b1;
                    seq_d.last_wr  = 1'b1;
                    seq_d.last_vld = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_RACC: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = ST_RSAMP;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_RSAMP: begin
                seq_d.state    = ST_IDLE;
                seq_d.ce_n     = 1'b1;
                seq_d.oe_n     = 1'b1;
                seq_d.done     = 1'b1;
                seq_d.last_wr  = 1'b0;
                seq_d.last_vld = 1'b1;
            end
            default: begin
                seq_d = seq_idle();
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= seq_idle();
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.state == ST_IDLE);
    assign accept    = req_valid & req_ready & ~mask_zero;
    assign capture   = (seq_q.state == ST_RSAMP);
    assign done      = seq_q.done;
    assign active    = ~seq_q.ce_n;
    assign mem_addr  = seq_q.addr;
    assign mem_ce_n  = seq_q.ce_n;
    assign mem_we_n  = seq_q.we_n;
    assign mem_oe_n  = seq_q.oe_n;
    assign mem_dq_oe = seq_q.dq_oe;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 1,
    parameter int HOLD_CYC  = 1,
    parameter int RD_CYC    = 2,
    parameter int TURN_CYC  = 1,
    localparam int LANES    = DW / LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_mask,
    output logic             req_ready,
    output logic             rsp_done,
    output logic [DW-1:0]    rsp_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_ce_n,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic [LANES-1:0] mem_be_n,
    output logic [DW-1:0]    mem_dq_out,
    output logic             mem_dq_oe,
    input  logic [DW-1:0]    mem_dq_in
);

    logic accept;
    logic capture;
    logic active;
    logic mask_zero;

    assign mask_zero = ~|req_mask;

    sram_ctrl_seq #(
        .AW        (AW),
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .RD_CYC    (RD_CYC),
        .TURN_CYC  (TURN_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .mask_zero (mask_zero),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .done      (rsp_done),
        .active    (active),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq_oe (mem_dq_oe)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_ctrl_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept),
            .sel_in   (req_mask[g]),
            .wdata_in (req_wdata[g*LANE_W +: LANE_W]),
            .active   (active),
            .capture  (capture),
            .dq_in    (mem_dq_in[g*LANE_W +: LANE_W]),
            .en_n     (mem_be_n[g]),
            .dq_out   (mem_dq_out[g*LANE_W +: LANE_W]),
            .rdata    (rsp_rdata[g*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int AW        = 16,
    parameter int LANES     = 2,
    parameter int PULSE_CYC = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LANES-1:0] req_mask,
    input logic             rsp_done,
    input logic [AW-1:0]    mem_addr,
    input logic             mem_ce_n,
    input logic             mem_we_n,
    input logic             mem_oe_n,
    input logic [LANES-1:0] mem_be_n,
    input logic             mem_dq_oe
);

    logic [31:0] we_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
        end else if (!mem_we_n) begin
            we_low_cnt <= we_low_cnt + 1'b1;
        end else begin
            we_low_cnt <= '0;
        end
    end

    // R2: write strobe only inside a selected cycle
    p_we_in_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    // R2: strobe width equals the pulse parameter
    p_we_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == 32'(PULSE_CYC)));

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

    p_drive_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    p_hold_after_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> (mem_dq_oe && !mem_ce_n));

    p_lanes_need_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_be_n != {LANES{1'b1}}) |-> !mem_ce_n);

    p_zero_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_mask == '0)) |=> (rsp_done && mem_ce_n));

    p_no_contention_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

    p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);

endmodule

bind sram_ctrl sram_ctrl_checker #(
    .AW        (AW),
    .LANES     (LANES),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mask  (req_mask),
    .rsp_done  (rsp_done),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;

    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int LANES = 2;
    localparam int SC    = 2;
    localparam int PC    = 3;
    localparam int HC    = 1;
    localparam int RC    = 2;
    localparam int TC    = 2;
    localparam int NW    = 1 << AW;
    localparam int WLAT  = SC + PC + HC;
    localparam int RLAT  = RC + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [DW-1:0]    req_wdata = '0;
    logic [LANES-1:0] req_mask = '0;
    logic             req_ready;
    logic             rsp_done;
    logic [DW-1:0]    rsp_rdata;
    logic [AW-1:0]    mem_addr;
    logic             mem_ce_n;
    logic             mem_we_n;
    logic             mem_oe_n;
    logic [LANES-1:0] mem_be_n;
    logic [DW-1:0]    mem_dq_out;
    logic             mem_dq_oe;
    logic [DW-1:0]    mem_dq_in;

    always #5 clk = ~clk;

    sram_ctrl #(
        .AW(AW), .DW(DW), .SETUP_CYC(SC), .PULSE_CYC(PC),
        .HOLD_CYC(HC), .RD_CYC(RC), .TURN_CYC(TC)
    ) u_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // behavioural memory following the select/strobe truth table
    logic [DW-1:0] mem [0:NW-1];
    logic [DW-1:0] exp_mem [0:NW-1];
    logic          mdrive;

    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n) begin
            if (!mem_be_n[0]) mem[mem_addr][7:0]  <= mem_dq_out[7:0];
            if (!mem_be_n[1]) mem[mem_addr][15:8] <= mem_dq_out[15:8];
        end
    end

    always_comb begin
        mdrive    = !mem_ce_n && !mem_oe_n && mem_we_n && (mem_be_n != 2'b11);
        mem_dq_in = 'z;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (!mem_be_n[0]) mem_dq_in[7:0]  = mem[mem_addr][7:0];
            if (!mem_be_n[1]) mem_dq_in[15:8] = mem[mem_addr][15:8];
        end
    end

    int checks = 0;
    int fails  = 0;
    int contention = 0;
    int undriven_wr = 0;
    int ce_low_cnt = 0;
    int we_low_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mdrive && mem_dq_oe) contention++;
            if (!mem_we_n && !mem_dq_oe) undriven_wr++;
            if (!mem_ce_n) ce_low_cnt++;
            if (!mem_we_n) we_low_cnt++;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic do_req(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [LANES-1:0] m, output logic [DW-1:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_mask  = m;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_done && lat < 60) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        rd = rsp_rdata;
    endtask

    function automatic logic [DW-1:0] pat_a(int a);
        return 16'((a * 977) ^ 16'h5A3C);
    endfunction

    function automatic logic [DW-1:0] pat_b(int a);
        return 16'((a * 16'h0301) + 16'h00C7);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_test();
    end

    initial begin
        logic [DW-1:0] rd;
        int            lat;
        int            ce0, we0;
        for (int i = 0; i < NW; i++) begin
            mem[i]     = 16'hC3C3;
            exp_mem[i] = 16'hC3C3;
        end
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 ce_n in reset", 32'(mem_ce_n), 32'd1);
        chk("R1 dq_oe in reset", 32'(mem_dq_oe), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobes after reset", {29'd0, mem_ce_n, mem_we_n, mem_oe_n}, 32'h7);
        chk("R1 lanes after reset", 32'(mem_be_n), 32'h3);
        chk("R1 ready/done after reset", {30'd0, req_ready, rsp_done}, 32'h2);

        // R2 full-word writes over every address, first one without turnaround
        we0 = we_low_cnt;
        for (int a = 0; a < NW; a++) begin
            do_req(1'b1, AW'(a), pat_a(a), 2'b11, rd, lat);
            exp_mem[a] = pat_a(a);
            chk("R2 write latency", 32'(lat), 32'(WLAT));
        end
        chk("R2 write strobe cycles", 32'(we_low_cnt - we0), 32'(NW * PC));

        // R5 R9 full-word reads, first after a write pays the turnaround
        for (int a = 0; a < NW; a++) begin
            do_req(1'b0, AW'(a), 16'h0, 2'b11, rd, lat);
            chk("R5 read data", 32'(rd), 32'(exp_mem[a]));
            chk((a == 0) ? "R9 read after write latency" : "R5 read latency",
                32'(lat), 32'((a == 0) ? RLAT + TC : RLAT));
        end

        // R6 single-lane writes, alternating lanes
        for (int a = 0; a < NW; a++) begin
            logic [1:0] m;
            m = (a % 2 == 0) ? 2'b01 : 2'b10;
            do_req(1'b1, AW'(a), pat_b(a), m, rd, lat);
            if (m[0]) exp_mem[a][7:0]  = pat_b(a) >> 0;
            if (m[1]) exp_mem[a][15:8] = pat_b(a) >> 8;
            chk((a == 0) ? "R9 write after read latency" : "R2 lane write latency",
                32'(lat), 32'((a == 0) ? WLAT + TC : WLAT));
        end
        for (int a = 0; a < NW; a++) begin
            do_req(1'b0, AW'(a), 16'h0, 2'b11, rd, lat);
            chk("R6 lane merge", 32'(rd), 32'(exp_mem[a]));
        end

        // R7 partial-lane reads
        for (int a = 0; a < 8; a++) begin
            do_req(1'b0, AW'(a), 16'h0, 2'b01, rd, lat);
            chk("R7 lower-only read", 32'(rd), {16'd0, 8'd0, exp_mem[a][7:0]});
            do_req(1'b0, AW'(a), 16'h0, 2'b10, rd, lat);
            chk("R7 upper-only read", 32'(rd), {16'd0, exp_mem[a][15:8], 8'd0});
            chk("R5 read latency same direction", 32'(lat), 32'(RLAT));
        end

        // R8 zero-mask write and read: no select, no change, no direction update
        ce0 = ce_low_cnt;
        do_req(1'b1, AW'(5), 16'hFFFF, 2'b00, rd, lat);
        chk("R8 zero-mask write latency", 32'(lat), 32'd0);
        do_req(1'b0, AW'(9), 16'h0, 2'b00, rd, lat);
        chk("R8 zero-mask read latency", 32'(lat), 32'd0);
        chk("R8 no chip select", 32'(ce_low_cnt - ce0), 32'd0);
        do_req(1'b0, AW'(5), 16'h0, 2'b11, rd, lat);
        chk("R8 memory untouched", 32'(rd), 32'(exp_mem[5]));
        chk("R8 direction kept after zero-mask write", 32'(lat), 32'(RLAT));

        // R9 alternating directions
        for (int a = 0; a < 6; a++) begin
            do_req(1'b1, AW'(a + 20), pat_b(a + 100), 2'b11, rd, lat);
            exp_mem[a + 20] = pat_b(a + 100);
            chk("R9 alternating write latency", 32'(lat), 32'(WLAT + TC));
            do_req(1'b0, AW'(a + 20), 16'h0, 2'b11, rd, lat);
            chk("R9 alternating read latency", 32'(lat), 32'(RLAT + TC));
            chk("R6 alternating read data", 32'(rd), 32'(exp_mem[a + 20]));
        end

        // R11 exactly one done per request: done low after a completed request
        @(negedge clk);
        chk("R11 single done pulse", 32'(rsp_done), 32'd0);
        chk("R11 ready while idle", 32'(req_ready), 32'd1);
        // R10 R4 bus monitors
        chk("R10 bus contention cycles", 32'(contention), 32'd0);
        chk("R4 write strobe without drive", 32'(undriven_wr), 32'd0);
        finish_test();
    end

endmodule